// File: doc/BRIEF.md
# Linked-List Pointer-Chasing Prefetch Sequencer

This block walks a singly linked list on behalf of a processor. It sits one level of the memory hierarchy below the processor. Software first programs a short kernel of load descriptors. Each descriptor holds a kind (recurrent next-pointer load or dependent load), a load PC, a byte offset and an end-of-kernel flag. It then starts a walk by presenting a list root address. The sequencer places that root in a small base-address FIFO. Whenever the FIFO has an entry and no iteration is being issued, it moves the FIFO head into a base register. It then steps through the kernel, issuing one prefetch request per cycle whose address is the base plus the descriptor offset.

Requests leave through a valid/ready stream backed by an 8-entry request queue. The consumer may hold `req_ready` low at any time. While it does, the head request stays on the outputs unchanged, and issue stalls once the queue is full. No request is ever lost. Memory returns the payload of recurrent loads on a response port. A non-zero value is the next node and is pushed into the base FIFO, which starts the next iteration. A zero (NULL) ends the walk. A stop input models handing the walk to a lower-level engine. It clears the iteration in progress and any queued bases. Requests already in the request queue are left in place.

Top module: `llist_walker`

## Requirements
- R1: After reset `req_valid` is 0 and `drop_cnt` is 0.
- R2: A write with `cfg_we`=1 stores kind, last flag, PC and offset into entry `cfg_idx`. Each iteration issues entries in index order from entry 0. It ends after the first entry whose last flag is 1, or after the highest entry if no flag is set.
- R3: A root accepted at rising edge e0 while the block is idle makes its first request visible on the outputs right after edge e0+2.
- R4: Each request carries the entry's kind on `req_rec` (1 = recurrent, 0 = dependent) and the entry's PC. Its `req_addr` is the base plus the zero-extended offset, modulo 2^ADDRW.
- R5: With `req_ready` held at 1, the requests of one iteration are accepted on consecutive cycles.
- R6: While `req_valid`=1 and `req_ready`=0, every request output holds its value. Up to 8 requests are held, issue stalls while the queue is full, and every issued request is later delivered in issue order.
- R7: A response with a non-zero `rsp_ptr` starts a new iteration using that value as the base. A response of zero starts nothing.
- R8: After an iteration, no further request appears until a response or a new root supplies a base.
- R9: A one-cycle `stop` ends the current iteration and discards all queued bases. Requests already queued are still delivered, and a later root starts normally.
- R10: A root or non-zero response that finds the 4-entry base FIFO full is dropped and counted in `drop_cnt`. A root that arrives in the same cycle as a non-zero response is dropped and counted. The counter saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop | input | 1 | Abort walk, flush base FIFO |
| cfg_we | input | 1 | Kernel entry write strobe |
| cfg_idx | input | IDXW | Kernel entry index |
| cfg_rec | input | 1 | Entry kind: 1 recurrent, 0 dependent |
| cfg_last | input | 1 | Entry ends the kernel |
| cfg_pc | input | PCW | Load PC of the entry |
| cfg_off | input | OFFW | Byte offset of the entry |
| root_valid | input | 1 | Root address present |
| root_addr | input | ADDRW | List root address |
| rsp_valid | input | 1 | Recurrent load data returned |
| rsp_ptr | input | ADDRW | Next-node pointer, zero ends walk |
| req_valid | output | 1 | Request available |
| req_ready | input | 1 | Consumer accepts request |
| req_rec | output | 1 | Request kind |
| req_pc | output | PCW | Request load PC |
| req_addr | output | ADDRW | Request address |
| drop_cnt | output | CNTW | Saturating count of dropped bases |

## Verification
A corrupted iteration index or base register shows up at once in the next accepted request, as a wrong PC, offset or address. A stuck active flag shows up as extra requests after an iteration that should have ended, or as missing ones. These faults are checked against an expected request list built from the kernel and the bases, cycle by cycle where timing is defined. Base FIFO faults surface only when a later iteration starts. They are therefore exercised by filling the FIFO behind a stalled request stream and comparing the full drain order and the drop count.

// File: rtl/lw_pkg.sv
package lw_pkg;
  typedef enum logic {
    KIND_DEP = 1'b0,
    KIND_REC = 1'b1
  } kind_e;
endpackage

// File: rtl/lw_fifo.sv
module lw_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push && !clr |-> !full);
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !clr |-> !empty);
endmodule

// File: rtl/lw_ktab.sv
module lw_ktab #(
  parameter int KENT = 4,
  parameter int PCW  = 16,
  parameter int OFFW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IDXW-1:0]      wr_idx,
  input  logic                 wr_rec,
  input  logic                 wr_last,
  input  logic [PCW-1:0]       wr_pc,
  input  logic [OFFW-1:0]      wr_off,
  input  logic [IDXW-1:0]      rd_idx,
  output logic                 rd_rec,
  output logic                 rd_last,
  output logic [PCW-1:0]       rd_pc,
  output logic [OFFW-1:0]      rd_off
);
  localparam int IDXW = (KENT > 1) ? $clog2(KENT) : 1;

  logic            rec_q  [KENT];
  logic            last_q [KENT];
  logic [PCW-1:0]  pc_q   [KENT];
  logic [OFFW-1:0] off_q  [KENT];

  for (genvar g = 0; g < KENT; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rec_q[g]  <= 1'b0;
        last_q[g] <= 1'b0;
        pc_q[g]   <= '0;
        off_q[g]  <= '0;
      end else if (we && wr_idx == IDXW'(g)) begin
        rec_q[g]  <= wr_rec;
        last_q[g] <= wr_last;
        pc_q[g]   <= wr_pc;
        off_q[g]  <= wr_off;
      end
    end
  end

  assign rd_rec  = rec_q[rd_idx];
  assign rd_last = last_q[rd_idx];
  assign rd_pc   = pc_q[rd_idx];
  assign rd_off  = off_q[rd_idx];
endmodule

// File: rtl/lw_seq.sv
module lw_seq
  import lw_pkg::*;
#(
  parameter int KENT  = 4,
  parameter int ADDRW = 32,
  parameter int PCW   = 16,
  parameter int OFFW  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop,
  input  logic             bf_empty,
  input  logic [ADDRW-1:0] bf_head,
  output logic             bf_pop,
  output logic [IDXW-1:0]  rd_idx,
  input  logic             k_rec,
  input  logic             k_last,
  input  logic [PCW-1:0]   k_pc,
  input  logic [OFFW-1:0]  k_off,
  input  logic             rq_full,
  output logic             iss_valid,
  output kind_e            iss_kind,
  output logic [PCW-1:0]   iss_pc,
  output logic [ADDRW-1:0] iss_addr
);
  localparam int IDXW = (KENT > 1) ? $clog2(KENT) : 1;

  logic             active;
  logic [IDXW-1:0]  idx;
  logic [ADDRW-1:0] base_q;
  logic             start, fin;

  assign start     = !active && !bf_empty && !stop;
  assign iss_valid = active && !rq_full && !stop;
  assign fin       = k_last || (idx == IDXW'(KENT - 1));
  assign bf_pop    = start;
  assign rd_idx    = idx;
  assign iss_kind  = kind_e'(k_rec);
  assign iss_pc    = k_pc;
  assign iss_addr  = base_q + ADDRW'(k_off);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      base_q <= '0;
    end else if (stop) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
      base_q <= bf_head;
    end else if (iss_valid) begin
      if (fin) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !active);
endmodule

// File: rtl/llist_walker.sv
module llist_walker
  import lw_pkg::*;
#(
  parameter int KENT     = 4,
  parameter int ADDRW    = 32,
  parameter int PCW      = 16,
  parameter int OFFW     = 12,
  parameter int BF_DEPTH = 4,
  parameter int RQ_DEPTH = 8,
  parameter int CNTW     = 8,
  localparam int IDXW    = (KENT > 1) ? $clog2(KENT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop,
  input  logic             cfg_we,
  input  logic [IDXW-1:0]  cfg_idx,
  input  logic             cfg_rec,
  input  logic             cfg_last,
  input  logic [PCW-1:0]   cfg_pc,
  input  logic [OFFW-1:0]  cfg_off,
  input  logic             root_valid,
  input  logic [ADDRW-1:0] root_addr,
  input  logic             rsp_valid,
  input  logic [ADDRW-1:0] rsp_ptr,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_rec,
  output logic [PCW-1:0]   req_pc,
  output logic [ADDRW-1:0] req_addr,
  output logic [CNTW-1:0]  drop_cnt
);
  localparam int RQW = 1 + PCW + ADDRW;

  logic             rsp_push, root_push, bf_push, bf_full, bf_empty, bf_pop;
  logic [ADDRW-1:0] bf_din, bf_head;
  logic [IDXW-1:0]  rd_idx;
  logic             k_rec, k_last;
  logic [PCW-1:0]   k_pc;
  logic [OFFW-1:0]  k_off;
  logic             rq_full, rq_empty, iss_valid;
  kind_e            iss_kind;
  logic [PCW-1:0]   iss_pc;
  logic [ADDRW-1:0] iss_addr;
  logic [RQW-1:0]   rq_din, rq_dout;
  logic [1:0]       ndrop;
  logic [CNTW:0]    drop_sum;

  assign rsp_push  = rsp_valid && (rsp_ptr != '0) && !stop;
  assign root_push = root_valid && !stop;
  assign bf_push   = rsp_push ? !bf_full : (root_push && !bf_full);
  assign bf_din    = rsp_push ? rsp_ptr : root_addr;
  assign ndrop     = {1'b0, rsp_push && bf_full}
                   + {1'b0, root_push && (rsp_push || bf_full)};
  assign drop_sum  = {1'b0, drop_cnt} + (CNTW+1)'(ndrop);

  always_ff @(posedge clk) begin
    if (!rst_n) drop_cnt <= '0;
    else if (drop_sum[CNTW]) drop_cnt <= '1;
    else drop_cnt <= drop_sum[CNTW-1:0];
  end

  lw_fifo #(.W(ADDRW), .DEPTH(BF_DEPTH)) u_basefifo (
    .clk(clk), .rst_n(rst_n), .clr(stop), .push(bf_push), .din(bf_din),
    .pop(bf_pop), .dout(bf_head), .full(bf_full), .empty(bf_empty)
  );

  lw_ktab #(.KENT(KENT), .PCW(PCW), .OFFW(OFFW)) u_ktab (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wr_idx(cfg_idx),
    .wr_rec(cfg_rec), .wr_last(cfg_last), .wr_pc(cfg_pc), .wr_off(cfg_off),
    .rd_idx(rd_idx), .rd_rec(k_rec), .rd_last(k_last), .rd_pc(k_pc),
    .rd_off(k_off)
  );

  lw_seq #(.KENT(KENT), .ADDRW(ADDRW), .PCW(PCW), .OFFW(OFFW)) u_seq (
    .clk(clk), .rst_n(rst_n), .stop(stop), .bf_empty(bf_empty),
    .bf_head(bf_head), .bf_pop(bf_pop), .rd_idx(rd_idx), .k_rec(k_rec),
    .k_last(k_last), .k_pc(k_pc), .k_off(k_off), .rq_full(rq_full),
    .iss_valid(iss_valid), .iss_kind(iss_kind), .iss_pc(iss_pc),
    .iss_addr(iss_addr)
  );

  assign rq_din = {iss_kind == KIND_REC, iss_pc, iss_addr};

  lw_fifo #(.W(RQW), .DEPTH(RQ_DEPTH)) u_reqq (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .push(iss_valid), .din(rq_din),
    .pop(req_valid && req_ready), .dout(rq_dout), .full(rq_full),
    .empty(rq_empty)
  );

  assign req_valid = !rq_empty;
  assign req_rec   = rq_dout[RQW-1];
  assign req_pc    = rq_dout[ADDRW +: PCW];
  assign req_addr  = rq_dout[ADDRW-1:0];

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_rec)
      && $stable(req_pc) && $stable(req_addr));
  p_drop_mono_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> drop_cnt >= $past(drop_cnt));
endmodule

// File: tb/llist_walker_test.sv
module llist_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stop = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic        cfg_rec = 1'b0, cfg_last = 1'b0;
  logic [15:0] cfg_pc = '0;
  logic [11:0] cfg_off = '0;
  logic        root_valid = 1'b0;
  logic [31:0] root_addr = '0;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_ptr = '0;
  logic        req_valid, req_ready = 1'b1, req_rec;
  logic [15:0] req_pc;
  logic [31:0] req_addr;
  logic [7:0]  drop_cnt;

  llist_walker uut (
    .clk(clk), .rst_n(rst_n), .stop(stop), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_rec(cfg_rec), .cfg_last(cfg_last),
    .cfg_pc(cfg_pc), .cfg_off(cfg_off), .root_valid(root_valid),
    .root_addr(root_addr), .rsp_valid(rsp_valid), .rsp_ptr(rsp_ptr),
    .req_valid(req_valid), .req_ready(req_ready), .req_rec(req_rec),
    .req_pc(req_pc), .req_addr(req_addr), .drop_cnt(drop_cnt)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int          n_chk = 0, n_fail = 0, n_log = 0, root_cyc = 0;
  logic        l_rec  [64];
  logic [15:0] l_pc   [64];
  logic [31:0] l_addr [64];
  int          l_cyc  [64];

  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready && n_log < 64) begin
      l_rec[n_log]  = req_rec;
      l_pc[n_log]   = req_pc;
      l_addr[n_log] = req_addr;
      l_cyc[n_log]  = cyc;
      n_log = n_log + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act,
                     input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg(input int i, input bit rec, input bit last,
                     input int pc, input int off);
    @(posedge clk); #1;
    cfg_we = 1; cfg_idx = 2'(i); cfg_rec = rec; cfg_last = last;
    cfg_pc = 16'(pc); cfg_off = 12'(off);
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic push_root(input logic [31:0] a);
    @(posedge clk); #1;
    root_valid = 1; root_addr = a; root_cyc = cyc;
    @(posedge clk); #1;
    root_valid = 0;
  endtask

  task automatic respond(input logic [31:0] p);
    @(posedge clk); #1;
    rsp_valid = 1; rsp_ptr = p;
    @(posedge clk); #1;
    rsp_valid = 0;
  endtask

  task automatic exp_req(input int i, input bit rec, input int pc,
                         input logic [31:0] addr, input string tag);
    chk(l_rec[i] == rec, {tag, " kind"}, l_rec[i], rec);
    chk(l_pc[i] == 16'(pc), {tag, " pc"}, l_pc[i], pc);
    chk(l_addr[i] == addr, {tag, " addr"}, l_addr[i], addr);
  endtask

  task automatic walk_kernel();
    cfg(0, 0, 0, 'h100, 8);
    cfg(1, 1, 0, 'h104, 0);
    cfg(2, 0, 1, 'h108, 'h10);
  endtask

  task automatic fill_kernel();
    for (int i = 0; i < 4; i++) cfg(i, i == 2, i == 3, 'h200 + 4 * i, 4 * i);
  endtask

  task automatic t_reset();
    chk(req_valid == 0, "R1 req_valid", req_valid, 0);
    chk(drop_cnt == 0, "R1 drop_cnt", drop_cnt, 0);
  endtask

  task automatic t_walk();
    walk_kernel();
    n_log = 0;
    push_root(32'h1000);
    tick(12);
    chk(n_log == 3, "R2 iteration length", n_log, 3);
    exp_req(0, 0, 'h100, 32'h1008, "R2");
    exp_req(1, 1, 'h104, 32'h1000, "R4");
    exp_req(2, 0, 'h108, 32'h1010, "R4");
    chk(l_cyc[0] == root_cyc + 3, "R3 first request cycle", l_cyc[0], root_cyc + 3);
    chk(l_cyc[1] == l_cyc[0] + 1, "R5 back to back", l_cyc[1], l_cyc[0] + 1);
    chk(l_cyc[2] == l_cyc[0] + 2, "R5 back to back", l_cyc[2], l_cyc[0] + 2);
    chk(n_log == 3, "R8 wait for pointer", n_log, 3);
    respond(32'h2000);
    tick(12);
    chk(n_log == 6, "R7 next iteration", n_log, 6);
    exp_req(3, 0, 'h100, 32'h2008, "R7");
    exp_req(4, 1, 'h104, 32'h2000, "R7");
    exp_req(5, 0, 'h108, 32'h2010, "R7");
    respond(32'h0);
    tick(12);
    chk(n_log == 6, "R7 null ends walk", n_log, 6);
  endtask

  task automatic t_wrap();
    n_log = 0;
    push_root(32'hFFFF_FFF8);
    tick(12);
    chk(n_log == 3, "R4 wrap count", n_log, 3);
    chk(l_addr[0] == 32'h0, "R4 wrap addr", l_addr[0], 0);
    chk(l_addr[1] == 32'hFFFF_FFF8, "R4 wrap addr", l_addr[1], 32'hFFFF_FFF8);
    chk(l_addr[2] == 32'h8, "R4 wrap addr", l_addr[2], 8);
  endtask

  task automatic t_collide();
    n_log = 0;
    push_root(32'h3000);
    tick(8);
    @(posedge clk); #1;
    root_valid = 1; root_addr = 32'h5000; rsp_valid = 1; rsp_ptr = 32'h4000;
    @(posedge clk); #1;
    root_valid = 0; rsp_valid = 0;
    tick(12);
    chk(drop_cnt == 1, "R10 collision counted", drop_cnt, 1);
    chk(n_log == 6, "R10 pointer wins", n_log, 6);
    exp_req(3, 0, 'h100, 32'h4008, "R10");
    exp_req(5, 0, 'h108, 32'h4010, "R10");
    respond(32'h0);
    tick(12);
    chk(n_log == 6, "R10 root lost", n_log, 6);
  endtask

  task automatic t_fill();
    logic [31:0] a0;
    fill_kernel();
    req_ready = 0;
    n_log = 0;
    push_root(32'h1_0000); tick(8);
    push_root(32'h2_0000); tick(8);
    push_root(32'h3_0000); tick(4);
    for (int k = 4; k <= 7; k++) push_root(32'(k) << 16);
    tick(2);
    chk(drop_cnt == 1, "R10 no drop below full", drop_cnt, 1);
    push_root(32'h8_0000);
    tick(2);
    chk(drop_cnt == 2, "R10 full fifo drop", drop_cnt, 2);
    @(negedge clk);
    a0 = req_addr;
    chk(req_valid == 1, "R6 valid held", req_valid, 1);
    tick(3);
    @(negedge clk);
    chk(req_addr == a0 && a0 == 32'h1_0000, "R6 head stable", req_addr, 32'h1_0000);
    for (int k = 0; k < 300; k++) push_root(32'h9_0000);
    tick(2);
    chk(drop_cnt == 8'hFF, "R10 saturation", drop_cnt, 8'hFF);
    chk(n_log == 0, "R6 nothing accepted while stalled", n_log, 0);
    req_ready = 1;
    tick(80);
    chk(n_log == 28, "R6 all delivered", n_log, 28);
    for (int i = 0; i < 28 && i < n_log; i++)
      exp_req(i, (i % 4) == 2, 'h200 + 4 * (i % 4),
              (32'(i / 4 + 1) << 16) + 32'(4 * (i % 4)), "R6 order");
  endtask

  task automatic t_stop();
    req_ready = 0;
    n_log = 0;
    push_root(32'h10_0000); tick(8);
    push_root(32'h20_0000); tick(8);
    push_root(32'h30_0000); tick(4);
    push_root(32'h40_0000);
    push_root(32'h50_0000);
    @(posedge clk); #1;
    stop = 1;
    @(posedge clk); #1;
    stop = 0;
    tick(4);
    req_ready = 1;
    tick(40);
    chk(n_log == 8, "R9 only queued requests", n_log, 8);
    for (int i = 0; i < 8 && i < n_log; i++)
      chk(l_addr[i] == (32'(i / 4 + 1) << 20) + 32'(4 * (i % 4)),
          "R9 queued order", l_addr[i], (32'(i / 4 + 1) << 20) + 32'(4 * (i % 4)));
    chk(drop_cnt == 8'hFF, "R9 no drops from flush", drop_cnt, 8'hFF);
    push_root(32'h90_0000);
    tick(12);
    chk(n_log == 12, "R9 restart after stop", n_log, 12);
    if (n_log > 8) exp_req(8, 0, 'h200, 32'h90_0000, "R9");
  endtask

  bit done = 0;

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    t_reset();
    t_walk();
    t_wrap();
    t_collide();
    t_fill();
    t_stop();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule